// File: doc/BRIEF.md
# Interpolating Programmable Recursive Receive Filter

This block doubles the rate of a stream of 16-bit signed linear PCM receive samples and smooths the result with a recursive filter whose coefficients can be changed at run time. Each accepted input sample is followed by one inserted zero sample. Both are run through the filter, so every input yields an ordered pair of outputs. At an 8 kHz input rate the output runs at 16 kHz. With suitable coefficients the same filter also acts as a frequency-response equalizer.

The filter has two modes. Extended mode uses three feedback (pole) taps and four feed-forward taps, which gives three zeros. Reduced mode keeps the four feed-forward taps, disables the third feedback tap and holds its delay element at zero. Coefficients and the mode bit are written through a plain register write port into a shadow bank. The shadow bank is copied into the working bank only when an input sample is accepted, so one output pair is never computed with two different coefficient sets.

Both sample interfaces are valid/ready. The input side accepts a sample on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only when no output is being held. The output side presents a result on `out_valid` and holds it unchanged until `out_ready` takes it. While `out_ready` is low, no filter state advances and no new input is accepted.

Top module: `rx_interp_iir`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. The mode is extended, the first feed-forward coefficient is 16384 (1.0) and every other coefficient is 0, so input x produces the output pair x, 0.
- R2: `in_ready` is 1 exactly when `out_valid` is 0. A sample is taken only on an edge where `in_valid` and `in_ready` are both 1.
- R3: Each accepted sample produces exactly two outputs, in this order: first the filtered input sample, then the filtered inserted zero. `out_valid` rises in the cycle after acceptance.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1, `out_data` does not change and the filter state does not advance.
- R5: Register map, with signed Q2.14 data. Addresses 0 to 3 hold the feed-forward coefficients b0..b3, where b0 applies to the current sample. Addresses 4 to 6 hold the feedback coefficients a1..a3. Address 7 bit 0 selects the mode (1 = extended, 0 = reduced). Each output is y = floor((b0·x0 + b1·x1 + b2·x2 + b3·x3 − a1·y1 − a2·y2 − a3·y3) / 2^14), where xk and yk are the filter input and output k steps earlier.
- R6: In extended mode the a3·y3 term is part of the sum.
- R7: In reduced mode a3 is treated as 0 whatever was written, and the y3 delay element is held at 0.
- R8: An output beyond the 16-bit signed range saturates to 32767 or −32768 instead of wrapping.
- R9: A register write reaches the datapath at the next input acceptance. A write made between the two outputs of a pair does not change the second output.
- R10: The sum is formed without overflow for any coefficients and samples, even when all seven products are at full scale at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take an input sample |
| in_data | input | 16 | Signed PCM input sample |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream takes the output sample |
| out_data | output | 16 | Signed filtered output sample |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 16 | Register write data |

## Verification
The bench programs mixed-sign coefficients with strong feedback and compares every output with a model of the difference equation. A swapped tap, a wrong sign or a round-toward-zero shift would show up as a mismatch within a few samples. It runs the same coefficients in reduced mode, so a design that still used a3 or kept stale y3 history would drift away from the model. It stalls `out_ready` to catch data that changes under back-pressure. It writes coefficients between the two outputs of a pair to catch a bank that switches early. It drives full-scale inputs with all taps at maximum, which exposes a wrapping result or an accumulator that is too narrow.

// File: rtl/rxi_pkg.sv
package rxi_pkg;
  parameter int DATA_W   = 16;
  parameter int COEF_W   = 16;
  parameter int FRAC_W   = 14;
  parameter int ACC_W    = 36;
  parameter int NUM_B    = 4;
  parameter int NUM_A    = 3;
  parameter int NUM_COEF = NUM_B + NUM_A;
  parameter int ADDR_W   = $clog2(NUM_COEF + 1);
  parameter int MODE_ADDR = NUM_COEF;

  typedef logic signed [DATA_W-1:0] samp_t;
  typedef logic signed [COEF_W-1:0] coef_t;
  typedef logic signed [ACC_W-1:0]  acc_t;

  localparam acc_t SAMP_MAX = (acc_t'(1) <<< (DATA_W - 1)) - acc_t'(1);
  localparam acc_t SAMP_MIN = -(acc_t'(1) <<< (DATA_W - 1));
  localparam coef_t COEF_ONE = coef_t'(1) <<< FRAC_W;

  function automatic acc_t sext_s(samp_t v);
    return {{(ACC_W - DATA_W){v[DATA_W-1]}}, v};
  endfunction

  function automatic acc_t sext_c(coef_t v);
    return {{(ACC_W - COEF_W){v[COEF_W-1]}}, v};
  endfunction
endpackage

// File: rtl/rxi_coef_bank.sv
module rxi_coef_bank
  import rxi_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [COEF_W-1:0]   wdata,
  input  logic                load,
  output coef_t               b_eff [NUM_B],
  output coef_t               a_eff [NUM_A],
  output logic                ext_eff,
  output logic                ext_act
);
  coef_t shadow [NUM_COEF];
  coef_t active [NUM_COEF];
  logic  ext_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_COEF; k++) shadow[k] <= (k == 0) ? COEF_ONE : '0;
      ext_sh <= 1'b1;
    end else if (we) begin
      if (int'(addr) < NUM_COEF) shadow[addr] <= coef_t'(wdata);
      else if (int'(addr) == MODE_ADDR) ext_sh <= wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_COEF; k++) active[k] <= (k == 0) ? COEF_ONE : '0;
      ext_act <= 1'b1;
    end else if (load) begin
      for (int k = 0; k < NUM_COEF; k++) active[k] <= shadow[k];
      ext_act <= ext_sh;
    end
  end

  generate
    for (genvar k = 0; k < NUM_B; k++) begin : g_b
      assign b_eff[k] = load ? shadow[k] : active[k];
    end
    for (genvar k = 0; k < NUM_A; k++) begin : g_a
      assign a_eff[k] = load ? shadow[NUM_B + k] : active[NUM_B + k];
    end
  endgenerate

  assign ext_eff = load ? ext_sh : ext_act;
endmodule

// File: rtl/rxi_mac.sv
module rxi_mac
  import rxi_pkg::*;
(
  input  samp_t x_cur,
  input  samp_t x_hist [NUM_B-1],
  input  samp_t y_hist [NUM_A],
  input  coef_t b      [NUM_B],
  input  coef_t a      [NUM_A],
  input  logic  ext,
  output samp_t y
);
  acc_t  pb [NUM_B];
  acc_t  pa [NUM_A];
  samp_t xv [NUM_B];
  coef_t a_use [NUM_A];
  acc_t  acc;
  acc_t  scaled;

  generate
    for (genvar k = 0; k < NUM_B; k++) begin : g_ff
      if (k == 0) begin : g_cur
        assign xv[k] = x_cur;
      end else begin : g_old
        assign xv[k] = x_hist[k-1];
      end
      assign pb[k] = sext_c(b[k]) * sext_s(xv[k]);
    end
    for (genvar k = 0; k < NUM_A; k++) begin : g_fb
      if (k == NUM_A - 1) begin : g_last
        assign a_use[k] = ext ? a[k] : '0;
      end else begin : g_mid
        assign a_use[k] = a[k];
      end
      assign pa[k] = sext_c(a_use[k]) * sext_s(y_hist[k]);
    end
  endgenerate

  always_comb begin
    acc = '0;
    for (int k = 0; k < NUM_B; k++) acc = acc + pb[k];
    for (int k = 0; k < NUM_A; k++) acc = acc - pa[k];
    scaled = acc >>> FRAC_W;
    if (scaled > SAMP_MAX)      y = SAMP_MAX[DATA_W-1:0];
    else if (scaled < SAMP_MIN) y = SAMP_MIN[DATA_W-1:0];
    else                        y = scaled[DATA_W-1:0];
  end
endmodule

// File: rtl/rx_interp_iir.sv
module rx_interp_iir
  import rxi_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_W-1:0]   in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DATA_W-1:0]   out_data,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [COEF_W-1:0]   cfg_wdata
);
  logic  accept, out_fire, step, zero_pending;
  samp_t x_cur, y_new, y_last;
  samp_t x_hist [NUM_B-1];
  samp_t y_hist [NUM_A];
  coef_t b_eff  [NUM_B];
  coef_t a_eff  [NUM_A];
  logic  ext_eff, ext_act;
  logic  out_valid_q;
  samp_t out_data_q;

  assign in_ready = !out_valid_q;
  assign accept   = in_valid && in_ready;
  assign out_fire = out_valid_q && out_ready;
  assign step     = accept || (out_fire && zero_pending);
  assign x_cur    = accept ? samp_t'(in_data) : '0;
  assign y_last   = y_hist[NUM_A-1];

  rxi_coef_bank u_bank (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .load(accept), .b_eff(b_eff), .a_eff(a_eff), .ext_eff(ext_eff), .ext_act(ext_act)
  );

  rxi_mac u_mac (
    .x_cur(x_cur), .x_hist(x_hist), .y_hist(y_hist),
    .b(b_eff), .a(a_eff), .ext(ext_eff), .y(y_new)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_B - 1; k++) x_hist[k] <= '0;
      for (int k = 0; k < NUM_A; k++) y_hist[k] <= '0;
    end else if (step) begin
      x_hist[0] <= x_cur;
      for (int k = 1; k < NUM_B - 1; k++) x_hist[k] <= x_hist[k-1];
      y_hist[0] <= y_new;
      for (int k = 1; k < NUM_A - 1; k++) y_hist[k] <= y_hist[k-1];
      y_hist[NUM_A-1] <= ext_eff ? y_hist[NUM_A-2] : '0;
    end else if (!ext_act) begin
      y_hist[NUM_A-1] <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q  <= 1'b0;
      zero_pending <= 1'b0;
      out_data_q   <= '0;
    end else if (accept) begin
      out_valid_q  <= 1'b1;
      zero_pending <= 1'b1;
      out_data_q   <= y_new;
    end else if (out_fire) begin
      if (zero_pending) begin
        zero_pending <= 1'b0;
        out_data_q   <= y_new;
      end else begin
        out_valid_q  <= 1'b0;
      end
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;
endmodule

// File: rtl/rx_interp_iir_chk.sv
module rx_interp_iir_chk
  import rxi_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              ext_act,
  input samp_t             y_last
);
  logic [1:0] n_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) n_out <= 2'd2;
    else if (in_valid && in_ready) n_out <= 2'd0;
    else if (out_valid && out_ready) n_out <= n_out + 2'd1;
  end

  AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R2
  AST_ACCEPT_GIVES_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R3
  AST_PAIR_DONE_BEFORE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (n_out == 2'd2)); // R3
  AST_NO_EXTRA_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> (n_out < 2'd2)); // R3
  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R4
  AST_REDUCED_CLEARS_TAP: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_act |-> (y_last == '0)); // R7
endmodule

bind rx_interp_iir rx_interp_iir_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .ext_act(ext_act), .y_last(y_last)
);

// File: tb/rx_interp_iir_test.sv
`timescale 1ns/1ps
module rx_interp_iir_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0, cfg_we = 1'b0;
  logic in_ready, out_valid;
  logic [15:0] in_data = '0, out_data, cfg_wdata = '0;
  logic [2:0]  cfg_addr = '0;
  int total = 0, bad = 0;
  bit done = 0;

  longint sh [7], act [7];
  bit sh_ext, act_ext;
  longint xh [3], yh [3];
  longint e0, e1;

  always #2.5 clk = ~clk;

  rx_interp_iir uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
  );

  task automatic check(string req, longint actual, longint expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  function automatic longint step(longint x);
    longint acc, y, y3n;
    acc = act[0]*x + act[1]*xh[0] + act[2]*xh[1] + act[3]*xh[2]
        - act[4]*yh[0] - act[5]*yh[1] - (act_ext ? act[6]*yh[2] : 0);
    y = acc >>> 14;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    y3n = act_ext ? yh[1] : 0;
    yh[2] = y3n; yh[1] = yh[0]; yh[0] = y;
    xh[2] = xh[1]; xh[1] = xh[0]; xh[0] = x;
    return y;
  endfunction

  task automatic wr(int addr, longint val);
    cfg_we = 1'b1; cfg_addr = 3'(addr); cfg_wdata = 16'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    if (addr < 7) sh[addr] = longint'($signed(16'(val)));
    else sh_ext = val[0];
  endtask

  task automatic push(longint x);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = 16'(x);
    @(negedge clk);
    in_valid = 1'b0;
    act = sh; act_ext = sh_ext;
    e0 = step(x);
    e1 = step(0);
  endtask

  task automatic pop(string req, longint exp);
    check({req, " out_valid"}, longint'(out_valid), 1);
    check(req, longint'($signed(out_data)), exp);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic run_pair(string req, longint x);
    push(x);
    pop(req, e0);
    pop(req, e1);
  endtask

  task automatic t_reset;
    check("R1 out_valid after reset", longint'(out_valid), 0);
    check("R1 in_ready after reset", longint'(in_ready), 1);
    push(1000);
    check("R1 default pass first", longint'($signed(out_data)), 1000);
    pop("R1 default", 1000);
    pop("R3 inserted zero", 0);
    check("R2 ready after pair", longint'(in_ready), 1);
  endtask

  task automatic t_backpressure;
    push(-1234);
    check("R2 not ready while busy", longint'(in_ready), 0);
    in_valid = 1'b1; in_data = 16'd777;
    repeat (3) begin
      @(negedge clk);
      check("R4 held valid", longint'(out_valid), 1);
      check("R4 held data", longint'($signed(out_data)), e0);
    end
    in_valid = 1'b0;
    pop("R4 first", e0);
    repeat (2) @(negedge clk);
    check("R4 second held", longint'($signed(out_data)), e1);
    pop("R3 second", e1);
    check("R3 idle after two", longint'(out_valid), 0);
  endtask

  task automatic load_mix;
    wr(0, 8192); wr(1, 4096); wr(2, -2048); wr(3, 1024);
    wr(4, -9000); wr(5, 3000); wr(6, -2500);
  endtask

  task automatic t_extended;
    load_mix();
    wr(7, 1);
    foreach (xh[k]) ; 
    run_pair("R5 ext", 12000);
    run_pair("R6 ext", -7000);
    run_pair("R6 ext", 0);
    run_pair("R6 ext", 3000);
    run_pair("R5 ext", 20000);
  endtask

  task automatic t_reduced;
    wr(7, 0);
    run_pair("R7 reduced", 15000);
    run_pair("R7 reduced", -4000);
    run_pair("R7 reduced", 0);
    run_pair("R7 reduced", 9000);
  endtask

  task automatic t_saturate;
    for (int k = 0; k < 7; k++) wr(k, 0);
    wr(7, 1);
    wr(0, 32767);
    run_pair("R8 zero prime", 0);
    run_pair("R8 zero prime", 0);
    run_pair("R8 zero prime", 0);
    run_pair("R8 positive clip", 30000);
    run_pair("R8 negative clip", -30000);
    for (int k = 0; k < 4; k++) wr(k, 32767);
    for (int k = 4; k < 7; k++) wr(k, -32768);
    run_pair("R10 full scale", 32767);
    run_pair("R10 full scale", 32767);
    run_pair("R10 full scale", -32768);
    run_pair("R10 full scale", -32768);
  endtask

  task automatic t_coef_timing;
    for (int k = 0; k < 7; k++) wr(k, 0);
    wr(0, 16384); wr(1, 8192);
    run_pair("R9 setup", 0);
    push(4000);
    pop("R9 first", e0);
    wr(1, -16384);
    wr(0, 4096);
    pop("R9 second keeps old", e1);
    run_pair("R9 new set", 4000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 7; k++) sh[k] = 0;
    sh[0] = 16384; sh_ext = 1;
    for (int k = 0; k < 3; k++) begin xh[k] = 0; yh[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_backpressure();
    t_extended();
    t_reduced();
    t_saturate();
    t_coef_timing();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule